// File: doc/BRIEF.md
# Parallel flash command and bus front end

This block is a clock-synchronous model of the control side of a parallel NOR flash part. It watches four active-low strobes (chip select, output enable, write enable, reset/power-down) and turns them into reads, writes, output release, standby and reset. A byte written through a write cycle goes to a command interpreter. That interpreter either picks a persistent read mode (array data, identification, status, query) or runs a program or erase sequence on a small internal array.

Reads are combinational from the pins. When the read conditions hold, the data of the current mode appears on `dq_out` in the same cycle and `dq_oe` goes high. While a program or erase is running, a cycle counter keeps the part busy. During that time every read returns the status byte and every write is dropped. Block 0 acts as the boot block. It can be changed only while `wp` is high.

Top module: `flash_cmd_bus`

## Requirements
- R1: After power-up and after `rp_n` goes high again, the read mode is array read. Array contents survive a reset.
- R2: The read mode changes only through a written command, and the mode then stays in effect: 0xFF selects array, 0x90 identification, 0x70 status and 0x98 query. Codes that are not defined leave the mode as it is.
- R3: `dq_oe` is 1 exactly when `rp_n`=1, `ce_n`=0, `oe_n`=0 and `we_n`=1. If `oe_n` or `ce_n` is high, `dq_oe` is 0 and `dq_out` is 0x00. A read just after reselection is valid at once.
- R4: While `rp_n` is low, the outputs are released and every other control input is ignored, including write pulses.
- R5: A write is accepted on the clock where `we_n` is seen rising from 0 to 1 while `ce_n`=0, `oe_n`=1 and `rp_n`=1. `addr` and `dq_in` are taken at that clock.
- R6: In identification mode, address 0 returns `MFR_ID`, address 1 returns `DEV_ID`, and every other address returns 0x00.
- R7: In query mode, addresses 0..4 return 0x51, 0x52, 0x59, `ADDR_W` and the block count (2^`BLK_W`). Every other address returns 0x00.
- R8: The status byte has bit 7 = ready (1 = idle), bit 5 = erase error, bit 4 = program error and bit 1 = locked-block error. All other bits are 0.
- R9: 0x40 followed by a data write programs that address with old AND new. Bit 7 of status then reads 0 for exactly `BUSY_CYCLES` clocks after the accepting clock, and the read mode becomes status.
- R10: 0x20 followed by 0xD0 sets every byte of the block holding the confirm address to 0xFF. The part is then busy for `BUSY_CYCLES` clocks and the mode becomes status.
- R11: A program or erase aimed at block 0 (the top `BLK_W` address bits all zero) while `wp`=0 is refused. It sets the locked-block error plus the program or erase error, does not go busy and leaves the data unchanged. Other blocks ignore `wp`.
- R12: A byte other than 0xD0 after 0x20 sets both the program and erase error bits and changes no data. Command 0x50 clears all three error bits.
- R13: While busy, reads return status in any mode and writes are ignored. The operation completes even if `ce_n` is high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; all strobes are sampled on its rising edge |
| rp_n | input | 1 | Reset/power-down, active low, asynchronous to the control state |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; its rising edge takes the write |
| wp | input | 1 | Write protect for block 0; high allows change |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Write data or command byte |
| dq_out | output | 8 | Read data; 0x00 when released |
| dq_oe | output | 1 | High when the part drives the data bus |

## Verification
The situation hardest to reach from the ports is a command or a deselect arriving inside the busy window. That window opens only after a full two-write program or erase sequence and lasts only a handful of clocks. The bench counts clocks from the accepting edge, so it can read status exactly one clock before and at the end of the window. It issues a mode command while the program is still running and holds chip select high for a whole erase. Afterwards it shows that the mode did not move and that the erased block reads 0xFF.

// File: rtl/flash_cmd_bus.sv
module flash_cmd_bus #(
  parameter int ADDR_W      = 5,
  parameter int BLK_W       = 2,
  parameter int BUSY_CYCLES = 6,
  parameter logic [7:0] MFR_ID = 8'h5A,
  parameter logic [7:0] DEV_ID = 8'h3E
) (
  input  logic              clk,
  input  logic              rp_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              wp,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int OFF_W = ADDR_W - BLK_W;
  localparam int BLK_SIZE = 1 << OFF_W;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [1:0] M_ARR = 2'd0, M_ID = 2'd1, M_STAT = 2'd2, M_QRY = 2'd3;
  localparam logic [1:0] P_NONE = 2'd0, P_PROG = 2'd1, P_ERASE = 2'd2;

  logic [7:0] mem [DEPTH];
  logic [1:0] mode_q, pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic we_q, perr_q, eerr_q, lerr_q;
  logic [7:0] status, rd_val;

  wire [BLK_W-1:0] blk = addr[ADDR_W-1 -: BLK_W];
  wire busy    = cnt_q != '0;
  wire locked  = (blk == '0) && !wp;
  wire wr_evt  = rp_n && !ce_n && oe_n && !we_q && we_n;
  wire wr_ok   = wr_evt && !busy;
  wire prog_go = wr_ok && pend_q == P_PROG && !locked;
  wire erase_go = wr_ok && pend_q == P_ERASE && dq_in == 8'hD0 && !locked;

  assign status = {!busy, 1'b0, eerr_q, perr_q, 2'b00, lerr_q, 1'b0};
  assign dq_oe  = rp_n && !ce_n && !oe_n && we_n;
  assign dq_out = dq_oe ? rd_val : 8'h00;

  always_ff @(posedge clk or negedge rp_n)
    if (!rp_n) we_q <= 1'b1;
    else       we_q <= we_n;

  always_ff @(posedge clk)
    if (prog_go)
      mem[addr] <= mem[addr] & dq_in;
    else if (erase_go)
      for (int i = 0; i < BLK_SIZE; i++)
        mem[{blk, i[OFF_W-1:0]}] <= 8'hFF;

  always_ff @(posedge clk or negedge rp_n) begin
    if (!rp_n) begin
      mode_q <= M_ARR;
      pend_q <= P_NONE;
      cnt_q  <= '0;
      perr_q <= 1'b0;
      eerr_q <= 1'b0;
      lerr_q <= 1'b0;
    end else begin
      if (busy) cnt_q <= cnt_q - 1'b1;
      if (wr_ok) begin
        pend_q <= P_NONE;
        case (pend_q)
          P_PROG: begin
            mode_q <= M_STAT;
            if (locked) begin perr_q <= 1'b1; lerr_q <= 1'b1; end
            else cnt_q <= CNT_W'(BUSY_CYCLES);
          end
          P_ERASE: begin
            mode_q <= M_STAT;
            if (dq_in != 8'hD0) begin perr_q <= 1'b1; eerr_q <= 1'b1; end
            else if (locked) begin eerr_q <= 1'b1; lerr_q <= 1'b1; end
            else cnt_q <= CNT_W'(BUSY_CYCLES);
          end
          default:
            case (dq_in)
              8'hFF: mode_q <= M_ARR;
              8'h90: mode_q <= M_ID;
              8'h70: mode_q <= M_STAT;
              8'h98: mode_q <= M_QRY;
              8'h40: begin pend_q <= P_PROG;  mode_q <= M_STAT; end
              8'h20: begin pend_q <= P_ERASE; mode_q <= M_STAT; end
              8'h50: begin perr_q <= 1'b0; eerr_q <= 1'b0; lerr_q <= 1'b0; end
              default: ;
            endcase
        endcase
      end
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (busy) rd_val = status;
    else
      case (mode_q)
        M_ARR:  rd_val = mem[addr];
        M_STAT: rd_val = status;
        M_ID:
          if (addr == ADDR_W'(0))      rd_val = MFR_ID;
          else if (addr == ADDR_W'(1)) rd_val = DEV_ID;
        default:
          case (addr)
            ADDR_W'(0): rd_val = 8'h51;
            ADDR_W'(1): rd_val = 8'h52;
            ADDR_W'(2): rd_val = 8'h59;
            ADDR_W'(3): rd_val = 8'(ADDR_W);
            ADDR_W'(4): rd_val = 8'(1 << BLK_W);
            default:    rd_val = 8'h00;
          endcase
      endcase
  end
endmodule

// File: rtl/flash_cmd_bus_chk.sv
module flash_cmd_bus_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rp_n,
  input logic             wr_evt,
  input logic             busy,
  input logic             locked,
  input logic [CNT_W-1:0] cnt_q,
  input logic [1:0]       mode_q,
  input logic [1:0]       pend_q,
  input logic             dq_oe,
  input logic [7:0]       dq_out
);
  AST_RESET_TO_ARRAY: assert property (@(posedge clk) disable iff (!rp_n)
    $rose(rp_n) |-> (mode_q == 2'd0 && !busy)); // R1
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rp_n)
    !wr_evt |=> $stable(mode_q)); // R2
  AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rp_n)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R13
  AST_BUSY_READS_STATUS: assert property (@(posedge clk) disable iff (!rp_n)
    (busy && dq_oe) |-> (dq_out[7] == 1'b0)); // R13
  AST_LOCKED_REFUSED: assert property (@(posedge clk) disable iff (!rp_n)
    (wr_evt && !busy && pend_q == 2'd1 && locked) |=> !busy); // R11
endmodule

bind flash_cmd_bus flash_cmd_bus_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rp_n(rp_n), .wr_evt(wr_evt), .busy(busy), .locked(locked),
  .cnt_q(cnt_q), .mode_q(mode_q), .pend_q(pend_q), .dq_oe(dq_oe), .dq_out(dq_out)
);

// File: tb/flash_cmd_bus_tb.sv
module flash_cmd_bus_tb;
  localparam int AW = 5, BW = 2, B = 6;
  localparam int DEPTH = 1 << AW, BSZ = 1 << (AW - BW);
  localparam logic [7:0] MFR = 8'h5A, DEV = 8'h3E;

  logic clk = 0, rp_n = 0, ce_n = 1, oe_n = 1, we_n = 1, wp = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] dq_in = '0, dq_out;
  logic dq_oe;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  flash_cmd_bus #(.ADDR_W(AW), .BLK_W(BW), .BUSY_CYCLES(B), .MFR_ID(MFR), .DEV_ID(DEV)) u_dut (
    .clk(clk), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .wp(wp),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  function automatic logic [7:0] pat(int a);
    return 8'(a * 37 + 5);
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wn(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk); ce_n = 0; oe_n = 1; addr = AW'(a); dq_in = d; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
  endtask

  task automatic rd(int a, output logic [7:0] v);
    ce_n = 0; oe_n = 0; we_n = 1; addr = AW'(a);
    #0.5; v = dq_out;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    ce_n = 0; oe_n = 0; wn(3);
    chk("R4 released in reset", {7'd0, dq_oe}, 8'h00);
    @(negedge clk); rp_n = 1; ce_n = 1; wp = 1;

    wr(0, 8'h20); wr(0, 8'hD0);
    rd(0, v); chk("R9 busy right after start", v, 8'h00);
    wn(B - 1); rd(5, v); chk("R9 still busy one clock before end", v[7:0], 8'h00);
    wn(1); rd(5, v); chk("R8 ready status after erase", v, 8'h80);
    for (int b = 1; b < (1 << BW); b++) begin wr(b * BSZ, 8'h20); wr(b * BSZ, 8'hD0); wn(B); end
    wr(0, 8'hFF);
    for (int a = 0; a < DEPTH; a++) begin rd(a, v); chk("R10 erased", v, 8'hFF); end

    for (int a = 0; a < DEPTH; a++) begin wr(a, 8'h40); wr(a, pat(a)); wn(B); end
    rd(0, v); chk("R9 mode is status after program", v, 8'h80);
    wr(0, 8'hFF);
    for (int a = 0; a < DEPTH; a++) begin rd(a, v); chk("R9 programmed", v, pat(a)); end
    wr(3, 8'h40); wr(3, 8'h0F); wn(B); wr(0, 8'hFF);
    rd(3, v); chk("R9 program ANDs", v, pat(3) & 8'h0F);

    wr(0, 8'h90);
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v); chk("R6 id", v, a == 0 ? MFR : a == 1 ? DEV : 8'h00);
    end
    wr(0, 8'h98);
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] e;
      case (a) 0: e = 8'h51; 1: e = 8'h52; 2: e = 8'h59; 3: e = 8'(AW); 4: e = 8'(1 << BW); default: e = 8'h00; endcase
      rd(a, v); chk("R7 query", v, e);
    end
    wr(0, 8'h11);
    rd(1, v); chk("R2 undefined code keeps mode", v, 8'h52);
    wr(0, 8'h70);
    rd(17, v); chk("R2 status mode", v, 8'h80);

    wp = 0;
    wr(2, 8'h40); wr(2, 8'h00);
    rd(2, v); chk("R11 locked program", v, 8'h92);
    wr(0, 8'hFF); rd(2, v); chk("R11 data kept", v, pat(2));
    wr(0, 8'h50); wr(0, 8'h70); rd(0, v); chk("R12 clear status", v, 8'h80);
    wr(0, 8'h20); wr(1, 8'hD0);
    rd(1, v); chk("R11 locked erase", v, 8'hA2);
    wr(0, 8'h50);
    wr(9, 8'h40); wr(9, 8'h00); wn(B);
    wr(0, 8'hFF); rd(9, v); chk("R11 other block ignores wp", v, 8'h00);
    rd(0, v); chk("R11 block 0 not erased", v, pat(0));
    wp = 1;

    wr(8, 8'h20); wr(8, 8'h33);
    rd(8, v); chk("R12 bad confirm", v, 8'hB0);
    wr(0, 8'hFF); rd(10, v); chk("R12 no data change", v, pat(10));
    wr(0, 8'h50);

    ce_n = 0; oe_n = 1; we_n = 1; #0.5;
    chk("R3 oe high releases", {dq_oe, dq_out[6:0]}, 8'h00);
    ce_n = 1; oe_n = 0; #0.5;
    chk("R3 standby releases", {dq_oe, dq_out[6:0]}, 8'h00);
    ce_n = 0; #0.5;
    chk("R3 reselect no latency", {7'd0, dq_oe}, 8'h01);
    chk("R3 reselect data", dq_out, pat(addr));
    rd(11, v); chk("R5 read latched addr", v, pat(11));

    wr(16, 8'h20); wr(16, 8'hD0);
    ce_n = 1; wn(B + 1);
    wr(0, 8'hFF);
    for (int a = 16; a < 16 + BSZ; a++) begin rd(a, v); chk("R13 erase done in standby", v, 8'hFF); end

    wr(24, 8'h40); wr(24, 8'h00); wr(0, 8'h90); wn(B);
    rd(0, v); chk("R13 write while busy ignored", v, 8'h80);
    wr(0, 8'hFF); rd(24, v); chk("R9 program in last block", v, 8'h00);

    wr(0, 8'h90);
    @(negedge clk); rp_n = 0; ce_n = 0; oe_n = 1; we_n = 0; dq_in = 8'h70;
    @(negedge clk); we_n = 1;
    @(negedge clk); oe_n = 0;
    #0.5; chk("R4 released despite read strobes", {7'd0, dq_oe}, 8'h00);
    @(negedge clk); rp_n = 1; ce_n = 1;
    rd(0, v); chk("R1 array after reset, data kept", v, pat(0));
    rd(1, v); chk("R4 write in reset ignored", v, pat(1));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule